// File: doc/BRIEF.md
# Masked Status Alert Aggregator

This block sits beside the limit comparators of a hardware monitor. Each comparator reports an out-of-limit condition as a one-cycle pulse. The block keeps each pulse as a sticky bit in one of two status banks. It also drives a single active-low alert line that a host polls or takes as an interrupt. Software works through a small register port with write and read strobes, an 8-bit address and 8-bit data.

Two mask registers decide which status bits may pull the alert low. A mask only withholds the alert: the status bit is captured either way. One summary bit of the primary mask silences the whole secondary bank at once. Two configuration registers do three jobs. They enable the alert, choose which of two output pins carries it, and say whether the fan-4 tachometer pin is used as a thermal-throttle input. In that thermal mode, the fan-4 status slot records the thermal event in place of the fan fault.

Reading a status register returns its contents and clears it. A condition that pulses in the same cycle as the read is kept for the next read. Register map: primary status 0x41, secondary status 0x42, primary mask 0x74, secondary mask 0x75, pin-A config 0x78, pin-B config 0x7D.

Top module: `alert_agg_top`

## Requirements
- R1: After synchronous reset, every register reads 0x00, no status bit is held, both alert pins are high and rdata is 0x00.
- R2: A pulse on evt_a[i] for i in 0..6, or on evt_b[i] for i in 0..7, sets status bit i of that bank on the clock edge where the pulse is sampled. The bit stays set until that bank is read. evt_a[7] has no effect.
- R3: A mask bit set to 1 never prevents its status bit from being captured.
- R4: One cycle after status changes, the enabled alert pin is low exactly when (status_a[6:0] & ~mask_a[6:0]) is nonzero, or when mask_a[7] is 0 and (status_b & ~mask_b) is nonzero.
- R5: mask_a bit 7 suppresses the alert for every bit of the secondary bank. Bit 7 of a primary status read returns the OR of all secondary status bits.
- R6: When bit 1 of the 0x7D config register is 1, secondary status bit 5 captures therm_evt and ignores evt_b[5]. When that bit is 0, bit 5 captures evt_b[5] and ignores therm_evt.
- R7: A read of 0x41 or 0x42 returns the bank contents held before the read and clears that bank. An event pulsed in the read cycle stays set afterwards.
- R8: Bit 0 of 0x7D routes the alert to alert_b_n and forces alert_a_n high. With that bit at 0, bit 0 of 0x78 routes the alert to alert_a_n. With both bits at 0, both pins stay high.
- R9: Writes to addresses other than 0x74, 0x75, 0x78 and 0x7D change nothing, and reads of unmapped addresses return 0x00. Mapped writable registers read back their written value.
- R10: rdata is registered. It carries the addressed value on the clock edge that samples rd_en, and it holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| evt_a | input | 8 | Primary-bank event pulses (bit 7 unused) |
| evt_b | input | 8 | Secondary-bank event pulses |
| therm_evt | input | 1 | Thermal-throttle event pulse from the tach-4 pin |
| alert_a_n | output | 1 | Active-low alert, pin A |
| alert_b_n | output | 1 | Active-low alert, pin B |

## Verification
The bench builds the block with its default 8-bit data and address widths and the default register map. It sweeps every single event bit of both banks against every single-bit mask setting and against the no-mask setting. Each of these combinations is checked for capture, alert level, read-back and clear, and the expected values are derived from the bit arithmetic in R2 to R5. Directed sequences cover the thermal remap, pin routing, the read-cycle event race and unmapped accesses.

// File: rtl/alert_pkg.sv
package alert_pkg;
  typedef struct packed {
    logic pin_a_en;
    logic pin_b_en;
    logic therm_on_tach;
  } alert_cfg_t;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/alert_cfg_regs.sv
module alert_cfg_regs
  import alert_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_MASK_A = 8'h74,
  parameter logic [AW-1:0] A_MASK_B = 8'h75,
  parameter logic [AW-1:0] A_CFG_A  = 8'h78,
  parameter logic [AW-1:0] A_CFG_B  = 8'h7D,
  parameter int EN_BIT    = 0,
  parameter int THERM_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_a,
  output logic [DW-1:0] mask_b,
  output logic [DW-1:0] cfg_a,
  output logic [DW-1:0] cfg_b,
  output alert_cfg_t    cfg
);
  logic hit_ma, hit_mb, hit_ca, hit_cb;

  assign hit_ma = wr_en && (addr == A_MASK_A);
  assign hit_mb = wr_en && (addr == A_MASK_B);
  assign hit_ca = wr_en && (addr == A_CFG_A);
  assign hit_cb = wr_en && (addr == A_CFG_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_a <= '0;
      mask_b <= '0;
      cfg_a  <= '0;
      cfg_b  <= '0;
    end else begin
      if (hit_ma) mask_a <= wdata;
      if (hit_mb) mask_b <= wdata;
      if (hit_ca) cfg_a  <= wdata;
      if (hit_cb) cfg_b  <= wdata;
    end
  end

  always_comb begin
    cfg.pin_a_en      = cfg_a[EN_BIT];
    cfg.pin_b_en      = cfg_b[EN_BIT];
    cfg.therm_on_tach = cfg_b[THERM_BIT];
  end

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_ma && !hit_mb && !hit_ca && !hit_cb) |=>
      ($stable(mask_a) && $stable(mask_b) && $stable(cfg_a) && $stable(cfg_b)));
endmodule

// File: rtl/alert_status_bank.sv
module alert_status_bank #(
  parameter int DW = 8,
  parameter logic [DW-1:0] CAPTURE = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] evt,
  input  logic          rd_clr,
  output logic [DW-1:0] status
);
  logic [DW-1:0] evt_kept;

  assign evt_kept = evt & CAPTURE;

  always_ff @(posedge clk) begin
    if (rst)         status <= '0;
    else if (rd_clr) status <= evt_kept;
    else             status <= status | evt_kept;
  end

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt_kept) |=> ((status & $past(evt_kept)) == $past(evt_kept)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !(|evt_kept)) |=> (status == '0));
endmodule

// File: rtl/alert_drive.sv
module alert_drive #(
  parameter int DW = 8,
  parameter int SUM_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] status_a,
  input  logic [DW-1:0] status_b,
  input  logic [DW-1:0] mask_a,
  input  logic [DW-1:0] mask_b,
  input  logic          pin_a_en,
  input  logic          pin_b_en,
  output logic          alert_a_n,
  output logic          alert_b_n
);
  logic [DW-1:0] own_a;
  logic          live_a, live_b, raise;

  always_comb begin
    own_a          = status_a & ~mask_a;
    own_a[SUM_BIT] = 1'b0;
    live_a         = |own_a;
    live_b         = !mask_a[SUM_BIT] && (|(status_b & ~mask_b));
    raise          = live_a || live_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_a_n <= 1'b1;
      alert_b_n <= 1'b1;
    end else begin
      alert_b_n <= !(raise && pin_b_en);
      alert_a_n <= !(raise && pin_a_en && !pin_b_en);
    end
  end

  // R8
  one_pin_chk: assert property (@(posedge clk) disable iff (rst)
    (alert_a_n || alert_b_n));

  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!pin_a_en && !pin_b_en) |=> (alert_a_n && alert_b_n));

  // R5
  sum_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_a[SUM_BIT] && !live_a) |=> (alert_a_n && alert_b_n));
endmodule

// File: rtl/alert_agg_top.sv
module alert_agg_top
  import alert_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [AW-1:0] A_STAT_A = 8'h41,
  parameter logic [AW-1:0] A_STAT_B = 8'h42,
  parameter logic [AW-1:0] A_MASK_A = 8'h74,
  parameter logic [AW-1:0] A_MASK_B = 8'h75,
  parameter logic [AW-1:0] A_CFG_A  = 8'h78,
  parameter logic [AW-1:0] A_CFG_B  = 8'h7D,
  parameter int SUM_BIT  = 7,
  parameter int TACH_BIT = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] evt_a,
  input  logic [DW-1:0] evt_b,
  input  logic          therm_evt,
  output logic          alert_a_n,
  output logic          alert_b_n
);
  localparam logic [DW-1:0] CAP_A = ~(DW'(1) << SUM_BIT);
  localparam logic [DW-1:0] CAP_B = '1;

  logic [DW-1:0] mask_a, mask_b, cfg_a, cfg_b;
  alert_cfg_t    cfg;
  logic [DW-1:0] bank_evt [NUM_BANKS];
  logic [DW-1:0] bank_st  [NUM_BANKS];
  logic          bank_clr [NUM_BANKS];
  logic [DW-1:0] evt_b_eff, stat_a_view, rd_mux;

  alert_cfg_regs #(
    .DW(DW), .AW(AW),
    .A_MASK_A(A_MASK_A), .A_MASK_B(A_MASK_B),
    .A_CFG_A(A_CFG_A), .A_CFG_B(A_CFG_B)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mask_a(mask_a), .mask_b(mask_b), .cfg_a(cfg_a), .cfg_b(cfg_b), .cfg(cfg)
  );

  // tach-4 slot carries either the fan fault or the thermal event
  always_comb begin
    evt_b_eff           = evt_b;
    evt_b_eff[TACH_BIT] = cfg.therm_on_tach ? therm_evt : evt_b[TACH_BIT];
  end

  assign bank_evt[0] = evt_a;
  assign bank_evt[1] = evt_b_eff;
  assign bank_clr[0] = rd_en && (addr == A_STAT_A);
  assign bank_clr[1] = rd_en && (addr == A_STAT_B);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    alert_status_bank #(
      .DW(DW), .CAPTURE(g == 0 ? CAP_A : CAP_B)
    ) u_bank (
      .clk(clk), .rst(rst), .evt(bank_evt[g]),
      .rd_clr(bank_clr[g]), .status(bank_st[g])
    );
  end

  always_comb begin
    stat_a_view          = bank_st[0];
    stat_a_view[SUM_BIT] = |bank_st[1];
    rd_mux = '0;
    if      (addr == A_STAT_A) rd_mux = stat_a_view;
    else if (addr == A_STAT_B) rd_mux = bank_st[1];
    else if (addr == A_MASK_A) rd_mux = mask_a;
    else if (addr == A_MASK_B) rd_mux = mask_b;
    else if (addr == A_CFG_A)  rd_mux = cfg_a;
    else if (addr == A_CFG_B)  rd_mux = cfg_b;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  alert_drive #(.DW(DW), .SUM_BIT(SUM_BIT)) u_drive (
    .clk(clk), .rst(rst),
    .status_a(bank_st[0]), .status_b(bank_st[1]),
    .mask_a(mask_a), .mask_b(mask_b),
    .pin_a_en(cfg.pin_a_en), .pin_b_en(cfg.pin_b_en),
    .alert_a_n(alert_a_n), .alert_b_n(alert_b_n)
  );

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R3
  masked_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_b_eff[0] && mask_b[0]) |=> bank_st[1][0]);
endmodule

// File: tb/tb_alert_agg_top.sv
module tb_alert_agg_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, therm_evt;
  logic [7:0] addr, wdata, rdata, evt_a, evt_b;
  logic       alert_a_n, alert_b_n;
  int         nvec = 0;
  int         nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alert_agg_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_a(evt_a), .evt_b(evt_b),
    .therm_evt(therm_evt), .alert_a_n(alert_a_n), .alert_b_n(alert_b_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  // pulse, then wait until the alert register has followed
  task automatic pulse(input logic [7:0] ea, input logic [7:0] eb, input logic th);
    @(negedge clk); evt_a = ea; evt_b = eb; therm_evt = th;
    @(negedge clk); evt_a = 0; evt_b = 0; therm_evt = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d, ma, mb, exp_a, exp_b;
    logic       exp_al;
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    evt_a = 0; evt_b = 0; therm_evt = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    chk("R1 alert_a_n", {7'd0, alert_a_n}, 8'h01);
    chk("R1 alert_b_n", {7'd0, alert_b_n}, 8'h01);
    chk("R1 rdata", rdata, 8'h00);
    rd(8'h74, d); chk("R1 mask_a", d, 8'h00);
    rd(8'h75, d); chk("R1 mask_b", d, 8'h00);
    rd(8'h78, d); chk("R1 cfg_a", d, 8'h00);
    rd(8'h41, d); chk("R1 stat_a", d, 8'h00);

    // R9 readback and unmapped access
    wr(8'h75, 8'h5A); rd(8'h75, d); chk("R9 readback", d, 8'h5A);
    wr(8'h50, 8'hFF); rd(8'h50, d); chk("R9 unmapped read", d, 8'h00);
    rd(8'h75, d); chk("R9 unmapped write", d, 8'h5A);
    wr(8'h75, 8'h00);

    // R2 R3 R4 R5 R7 sweep: pin A enabled
    wr(8'h78, 8'h01);
    for (int bank = 0; bank < 2; bank++) begin
      for (int ev = 0; ev < 8; ev++) begin
        for (int m = 0; m < 9; m++) begin
          ma = (bank == 0 && m < 8) ? (8'h01 << m) : 8'h00;
          mb = (bank == 1 && m < 8) ? (8'h01 << m) : 8'h00;
          wr(8'h74, ma); wr(8'h75, mb);
          if (bank == 0) begin
            pulse(8'h01 << ev, 8'h00, 1'b0);
            exp_a  = (ev != 7) ? (8'h01 << ev) : 8'h00;
            exp_b  = 8'h00;
            exp_al = (ev != 7) && (m != ev);
          end else begin
            pulse(8'h00, 8'h01 << ev, 1'b0);
            exp_a  = 8'h80;
            exp_b  = 8'h01 << ev;
            exp_al = (m != ev) && (m != 7 || 1'b1);
          end
          chk("R4 alert level", {7'd0, alert_a_n}, {7'd0, !exp_al});
          chk("R8 pin b idle", {7'd0, alert_b_n}, 8'h01);
          rd(8'h41, d); chk("R2 R3 R5 stat_a", d, exp_a);
          rd(8'h42, d); chk("R2 R3 stat_b", d, exp_b);
          @(negedge clk);
          chk("R7 cleared alert", {7'd0, alert_a_n}, 8'h01);
          rd(8'h42, d); chk("R7 cleared", d, 8'h00);
        end
      end
    end

    // R5 summary mask silences whole secondary bank
    wr(8'h74, 8'h80); wr(8'h75, 8'h00);
    pulse(8'h00, 8'hFF, 1'b0);
    chk("R5 summary mask", {7'd0, alert_a_n}, 8'h01);
    pulse(8'h04, 8'h00, 1'b0);
    chk("R5 primary still live", {7'd0, alert_a_n}, 8'h00);
    rd(8'h41, d); chk("R5 stat_a", d, 8'h84);
    rd(8'h42, d); chk("R3 stat_b kept", d, 8'hFF);
    wr(8'h74, 8'h00);

    // R6 tach/therm remap
    pulse(8'h00, 8'h00, 1'b1);
    rd(8'h42, d); chk("R6 therm ignored", d, 8'h00);
    wr(8'h7D, 8'h02);
    pulse(8'h00, 8'h20, 1'b0);
    rd(8'h42, d); chk("R6 fan4 ignored", d, 8'h00);
    pulse(8'h00, 8'h00, 1'b1);
    rd(8'h42, d); chk("R6 therm captured", d, 8'h20);

    // R8 routing to pin B
    wr(8'h7D, 8'h01);
    pulse(8'h02, 8'h00, 1'b0);
    chk("R8 pin b low", {7'd0, alert_b_n}, 8'h00);
    chk("R8 pin a high", {7'd0, alert_a_n}, 8'h01);
    rd(8'h41, d);

    // R7 event in the read cycle survives
    pulse(8'h00, 8'h01, 1'b0);
    @(negedge clk); rd_en = 1; addr = 8'h42; evt_b = 8'h08;
    @(negedge clk); rd_en = 0; evt_b = 0; d = rdata;
    chk("R7 read value", d, 8'h01);
    chk("R10 rdata held", rdata, 8'h01);
    rd(8'h42, d); chk("R7 racing event kept", d, 8'h08);

    // R8 disabled
    wr(8'h78, 8'h00); wr(8'h7D, 8'h00);
    pulse(8'h01, 8'h01, 1'b0);
    chk("R8 disabled a", {7'd0, alert_a_n}, 8'h01);
    chk("R8 disabled b", {7'd0, alert_b_n}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule